// File: doc/BRIEF.md
# 10 Mb/s MII Receive Sequencer

This block produces the receive half of a 10 Mb/s media-independent interface on the PHY side. Its inputs stand in for the analog and recovery front end: a squelch verdict, start and end of packet strobes, a recovered-clock lock flag, a link-fail flag, the decoded receive nibble, the free-running transmit clock and the recovered clock. From these it builds the receive clock, the carrier sense, the data-valid qualifier, the receive nibble and the receive error output. The transmit error input is accepted and has no effect.

All control runs on a fast sampling clock `clk`. Both source clocks are brought in through synchronizers. The receive clock is a register that follows whichever source is selected. While the line is quiet the receive clock follows the transmit clock. Once a packet has started and recovery has locked, the receive clock is moved over to the recovered clock without a runt phase, and data-valid and each nibble are then launched just after falling edges of the receive clock. At the end of the packet, carrier and data-valid drop together and the clock returns to the transmit source.

Top module: `mii10_rx_seq`

## Requirements
- R1: `rxer` is 0 in every cycle, and `tx_er` changes no output.
- R2: With no packet in progress, or while `squelch_ok` is 0, `rxclk` follows `tx_clk` (same half-period), `rxd` is 0, and `crs` and `rxdv` are 0. A `sop` pulse while `squelch_ok` is 0 leaves `crs` at 0.
- R3: A one-cycle `sop` pulse with `squelch_ok` at 1 makes `crs` 1 from the next `clk` cycle. `rxdv` stays 0 until `rec_lock` has been seen.
- R4: After `rec_lock` rises during carrier, `rxclk` changes over to `rec_clk` (half-period of `rec_clk`). `rxdv` then rises in a cycle where `rxclk` is low, just after a falling edge of the recovered clock.
- R5: While `rxdv` is 1, `rxd` takes the value of `dec_nib` one `clk` cycle after each falling edge of `rxclk`, and it holds that value at all other times. The first nibble is loaded in the same cycle as `rxdv` rises.
- R6: An `eop` pulse makes `crs` and `rxdv` 0 and `rxd` all zeros from the next `clk` cycle. `rxclk` then returns to `tx_clk`.
- R7: While `link_fail` is 1, `crs` and `rxdv` are 0 from the next cycle on, whatever the other inputs do (`sop` included). When `link_fail` is released the block is idle.
- R8: If `eop` arrives before `rec_lock`, `rxdv` never rises for that packet.
- R9: No high or low phase of `rxclk` is shorter than the shorter half-period of the two source clocks, less one `clk` cycle of sampling, and this includes the phases around a source change-over.
- R10: `squelch_ok` falling to 0 during a packet makes `crs` and `rxdv` 0 from the next cycle.
- R11: `sop` and `eop` in the same cycle while idle start no carrier.
- R12: `rxdv` is never 1 while `crs` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock for all control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_clk | input | 1 | Free-running transmit clock, 2.5 MHz in service |
| rec_clk | input | 1 | Clock from the recovery loop |
| squelch_ok | input | 1 | 1 when the line carries valid signal |
| sop | input | 1 | One-cycle start-of-packet strobe |
| eop | input | 1 | One-cycle end-of-packet strobe |
| rec_lock | input | 1 | Recovery loop has locked onto the packet |
| link_fail | input | 1 | Link is in the failed state |
| dec_nib | input | NIB_W | Nibble from the line decoder |
| tx_er | input | 1 | Transmit error, ignored at this rate |
| rxclk | output | 1 | Receive clock |
| rxd | output | NIB_W | Receive nibble |
| crs | output | 1 | Carrier sense |
| rxdv | output | 1 | Receive data valid |
| rxer | output | 1 | Receive error, held at 0 |

## Verification
A wrong sequencing state shows at `crs` and `rxdv` one `clk` cycle after the strobe that caused it, so the end and blocking checks sample exactly one cycle after each strobe. A selector that picks the wrong source, or that changes source at a bad moment, shows within one source period: either the measured high half-period of `rxclk` no longer matches the expected source, or a short phase appears next to the change-over. A misplaced nibble launch shows one cycle after the falling edge of `rxclk` as a mismatch against the nibble that was presented during the preceding high phase.

// File: rtl/mii10_pkg.sv
`timescale 1ns/1ps
package mii10_pkg;
   typedef enum logic [1:0] {
      RX_IDLE     = 2'd0,
      RX_CARRIER  = 2'd1,
      RX_DATA     = 2'd2,
      RX_LINKDOWN = 2'd3
   } rx_state_e;

   typedef enum logic {
      SEL_FOLLOW = 1'b0,
      SEL_PARK   = 1'b1
   } sel_phase_e;
endpackage

// File: rtl/mii10_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer for one asynchronous input.
module mii10_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mii10_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mii10_clk_sel.sv
`timescale 1ns/1ps
// Runt-free selector between two sampled clock levels.
// A change of source first lets the current source fall, then holds the
// output low until the target source itself falls, then follows the target.
// MIN_PHASE must not exceed the shorter source half-period in clk cycles.
module mii10_clk_sel #(
   parameter int MIN_PHASE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_lvl,
   input  logic rec_lvl,
   input  logic want_rec,
   output logic rxclk,
   output logic on_rec
);
   import mii10_pkg::*;

   localparam int CNT_W = $clog2(MIN_PHASE + 1) + 1;

   if (MIN_PHASE < 1) begin : g_bad_min
      $error("mii10_clk_sel: MIN_PHASE must be positive");
   end

   sel_phase_e phase_q;
   logic       cur_rec_q;
   logic       out_q;
   logic       tx_p_q, rec_p_q;
   logic       cur_src, tgt_src, tgt_prev;

   assign cur_src  = cur_rec_q ? rec_lvl : tx_lvl;
   assign tgt_src  = want_rec  ? rec_lvl : tx_lvl;
   assign tgt_prev = want_rec  ? rec_p_q : tx_p_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_p_q  <= 1'b0;
         rec_p_q <= 1'b0;
      end else begin
         tx_p_q  <= tx_lvl;
         rec_p_q <= rec_lvl;
      end
   end

   // Reset parks on the transmit clock so the first phase is whole.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= SEL_PARK;
         cur_rec_q <= 1'b0;
         out_q     <= 1'b0;
      end else begin
         unique case (phase_q)
            SEL_FOLLOW: begin
               out_q <= cur_src;
               if ((want_rec != cur_rec_q) && !cur_src) phase_q <= SEL_PARK;
            end
            SEL_PARK: begin
               out_q <= 1'b0;
               if (tgt_prev && !tgt_src) begin
                  cur_rec_q <= want_rec;
                  phase_q   <= SEL_FOLLOW;
               end
            end
            default: phase_q <= SEL_PARK;
         endcase
      end
   end

   assign rxclk  = out_q;
   assign on_rec = cur_rec_q && (phase_q == SEL_FOLLOW);

   // Phase-length watch: a counter replaces any long $past window.
   logic [CNT_W-1:0] hold_cnt;
   logic             out_prev_q;
   logic             seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt   <= '0;
         out_prev_q <= 1'b0;
         seen_q     <= 1'b0;
      end else begin
         out_prev_q <= out_q;
         if (out_q != out_prev_q) begin
            hold_cnt <= CNT_W'(1);
            seen_q   <= 1'b1;
         end else if (hold_cnt != {CNT_W{1'b1}}) begin
            hold_cnt <= hold_cnt + CNT_W'(1);
         end
      end
   end

   // R9
   min_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && (out_q != out_prev_q)) |-> (hold_cnt >= CNT_W'(MIN_PHASE)));

   // R9
   park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == SEL_PARK) && $past(phase_q == SEL_PARK) |-> !out_q);
endmodule

// File: rtl/mii10_rx_ctl.sv
`timescale 1ns/1ps
// Receive sequencing: carrier, data-valid and nibble launch.
module mii10_rx_ctl #(
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             squelch_ok,
   input  logic             sop,
   input  logic             eop,
   input  logic             rec_lock,
   input  logic             link_fail,
   input  logic [NIB_W-1:0] dec_nib,
   input  logic             fall_evt,
   input  logic             on_rec,
   output logic             crs,
   output logic             want_rec,
   output logic             rxdv,
   output logic [NIB_W-1:0] rxd
);
   import mii10_pkg::*;

   rx_state_e        st_q, st_d;
   logic             rxdv_q;
   logic [NIB_W-1:0] rxd_q;

   // Priority: link failure, then end or squelch loss, then lock.
   always_comb begin
      st_d = st_q;
      if (link_fail) begin
         st_d = RX_LINKDOWN;
      end else begin
         unique case (st_q)
            RX_IDLE:     if (squelch_ok && sop && !eop) st_d = RX_CARRIER;
            RX_CARRIER: begin
               if (eop || !squelch_ok) st_d = RX_IDLE;
               else if (rec_lock)      st_d = RX_DATA;
            end
            RX_DATA:     if (eop || !squelch_ok) st_d = RX_IDLE;
            RX_LINKDOWN: st_d = RX_IDLE;
            default:     st_d = RX_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= RX_IDLE;
      else        st_q <= st_d;
   end

   // Valid and nibble clear on the same edge the state leaves DATA,
   // so they never outlive carrier.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxdv_q <= 1'b0;
         rxd_q  <= '0;
      end else if (st_d != RX_DATA) begin
         rxdv_q <= 1'b0;
         rxd_q  <= '0;
      end else if (fall_evt && on_rec) begin
         rxdv_q <= 1'b1;
         rxd_q  <= dec_nib;
      end
   end

   assign crs      = (st_q == RX_CARRIER) || (st_q == RX_DATA);
   assign want_rec = (st_q == RX_DATA);
   assign rxdv     = rxdv_q;
   assign rxd      = rxd_q;

   // R3
   carrier_no_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RX_CARRIER) |-> !rxdv_q);

   // R11
   sop_eop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == RX_IDLE) && sop && eop) |=> !crs);

   // R8
   dv_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxdv_q) |-> (st_q == RX_DATA) && $past(st_q == RX_DATA));
endmodule

// File: rtl/mii10_rx_seq.sv
`timescale 1ns/1ps
// 10 Mb/s MII receive sequencer, top level.
module mii10_rx_seq #(
   parameter int NIB_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_PHASE   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_clk,
   input  logic             rec_clk,
   input  logic             squelch_ok,
   input  logic             sop,
   input  logic             eop,
   input  logic             rec_lock,
   input  logic             link_fail,
   input  logic [NIB_W-1:0] dec_nib,
   input  logic             tx_er,
   output logic             rxclk,
   output logic [NIB_W-1:0] rxd,
   output logic             crs,
   output logic             rxdv,
   output logic             rxer
);
   localparam int N_SRC = 2;

   if (NIB_W < 1) begin : g_bad_width
      $error("mii10_rx_seq: NIB_W must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mii10_rx_seq: SYNC_STAGES must be at least 2");
   end

   logic [N_SRC-1:0] src_raw, src_lvl;
   logic             want_rec, on_rec, rxclk_i, rxclk_prev_q, fall_evt;
   logic             unused_tx_er;

   assign src_raw      = {rec_clk, tx_clk};
   assign unused_tx_er = tx_er;

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      mii10_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (src_raw[s]),
         .q     (src_lvl[s])
      );
   end

   mii10_clk_sel #(.MIN_PHASE(MIN_PHASE)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_lvl   (src_lvl[0]),
      .rec_lvl  (src_lvl[1]),
      .want_rec (want_rec),
      .rxclk    (rxclk_i),
      .on_rec   (on_rec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rxclk_prev_q <= 1'b0;
      else        rxclk_prev_q <= rxclk_i;
   end
   assign fall_evt = rxclk_prev_q && !rxclk_i;

   mii10_rx_ctl #(.NIB_W(NIB_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .squelch_ok (squelch_ok),
      .sop        (sop),
      .eop        (eop),
      .rec_lock   (rec_lock),
      .link_fail  (link_fail),
      .dec_nib    (dec_nib),
      .fall_evt   (fall_evt),
      .on_rec     (on_rec),
      .crs        (crs),
      .want_rec   (want_rec),
      .rxdv       (rxdv),
      .rxd        (rxd)
   );

   assign rxclk = rxclk_i;
   assign rxer  = 1'b0;

   // R12
   dv_within_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rxdv |-> crs);

   // R7
   link_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_fail |=> (!crs && !rxdv));

   // R6
   eop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eop |=> (!crs && !rxdv && (rxd == '0)));

   // R10
   squelch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !squelch_ok |=> (!crs && !rxdv));

   // R4
   dv_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxdv) |-> !rxclk);

   // R5
   nib_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rxdv && $past(rxdv) && !$stable(rxd)) |-> ($past(rxclk, 2) && !$past(rxclk)));
endmodule

// File: tb/sim_mii10_rx_seq.sv
`timescale 1ns/1ps
module sim_mii10_rx_seq;
   localparam int TXH  = 10;   // tx_clk half-period in clk cycles
   localparam int RXH  = 14;   // rec_clk half-period in clk cycles
   localparam int MINH = (TXH < RXH) ? TXH : RXH;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       tx_clk = 1'b0, rec_clk = 1'b0;
   logic       squelch_ok = 1'b0, sop = 1'b0, eop = 1'b0;
   logic       rec_lock = 1'b0, link_fail = 1'b0, tx_er = 1'b0;
   logic [3:0] dec_nib = 4'd0;
   logic       rxclk, crs, rxdv, rxer;
   logic [3:0] rxd;

   int  checks = 0, fails = 0;
   int  len = 0, last_hi = 0;
   bit  seen = 1'b0, rxdv_ever = 1'b0;
   logic prev_rx = 1'b0;

   always #2.5 clk = ~clk;
   initial begin #1.3; forever #(TXH * 5.0) tx_clk = ~tx_clk; end
   initial begin #3.7; forever #(RXH * 5.0) rec_clk = ~rec_clk; end

   mii10_rx_seq #(.NIB_W(4), .SYNC_STAGES(2), .MIN_PHASE(4)) u0 (
      .clk(clk), .rst_n(rst_n), .tx_clk(tx_clk), .rec_clk(rec_clk),
      .squelch_ok(squelch_ok), .sop(sop), .eop(eop), .rec_lock(rec_lock),
      .link_fail(link_fail), .dec_nib(dec_nib), .tx_er(tx_er),
      .rxclk(rxclk), .rxd(rxd), .crs(crs), .rxdv(rxdv), .rxer(rxer)
   );

   function automatic bit in_band(int v, int centre);
      return (v >= centre - 1) && (v <= centre + 1);
   endfunction

   function automatic bit phase_ok(int l);
      return l >= MINH - 1;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Continuous port monitor: phase widths, rxer, rxdv within crs.
   always @(negedge clk) begin
      if (!rst_n) begin
         seen = 1'b0; len = 0; prev_rx = rxclk;
      end else begin
         if (rxclk !== prev_rx) begin
            if (seen) check(phase_ok(len), "R9 rxclk phase width", len, MINH - 1);
            if (prev_rx === 1'b1) last_hi = len;
            seen = 1'b1;
            len = 1;
         end else begin
            len++;
         end
         prev_rx = rxclk;
         check(rxer === 1'b0, "R1 rxer low", int'(rxer), 0);
         check(!(rxdv && !crs), "R12 rxdv within crs", int'(crs), 1);
         if (!rxdv) check(rxd == 4'd0, "R2 rxd zero when not valid", int'(rxd), 0);
         if (rxdv) rxdv_ever = 1'b1;
      end
   end

   // tx_er toggles randomly for the whole run (R1).
   initial begin
      forever begin
         @(negedge clk);
         tx_er = 1'($urandom % 2);
      end
   end

   task automatic wait_lvl(logic v);
      do @(negedge clk); while (rxclk !== v);
   endtask

   task automatic run_packet(int lock_dly, int nnib, int end_kind);
      logic [3:0] exp_nib;
      dec_nib = 4'($urandom % 16);
      @(negedge clk) sop = 1'b1;
      @(negedge clk) sop = 1'b0;
      check(crs == 1'b1, "R3 carrier after sop", int'(crs), 1);
      check(rxdv == 1'b0, "R3 no valid before lock", int'(rxdv), 0);
      repeat (lock_dly) @(negedge clk);
      check(rxdv == 1'b0, "R3 no valid while unlocked", int'(rxdv), 0);
      check(crs == 1'b1, "R3 carrier held", int'(crs), 1);
      rec_lock = 1'b1;
      for (int k = 0; k < 300 && !rxdv; k++) @(negedge clk);
      check(rxdv == 1'b1, "R4 valid after lock", int'(rxdv), 1);
      check(rxclk == 1'b0, "R4 valid rises while rxclk low", int'(rxclk), 0);
      check(rxd == dec_nib, "R5 first nibble", int'(rxd), int'(dec_nib));
      exp_nib = dec_nib;
      for (int i = 0; i < nnib; i++) begin
         wait_lvl(1'b1);
         check(rxd == exp_nib, "R5 nibble held in high phase", int'(rxd), int'(exp_nib));
         dec_nib = 4'($urandom % 16);
         wait_lvl(1'b0);
         exp_nib = dec_nib;
         @(negedge clk);
         check(rxd == exp_nib, "R5 nibble after falling edge", int'(rxd), int'(exp_nib));
      end
      check(in_band(last_hi, RXH), "R4 rxclk from recovered clock", last_hi, RXH);
      if (end_kind == 2) begin
         @(negedge clk) squelch_ok = 1'b0;
         @(negedge clk);
         check(crs == 1'b0 && rxdv == 1'b0, "R10 squelch loss ends packet",
               int'({crs, rxdv}), 0);
         squelch_ok = 1'b1;
      end else if (end_kind == 3) begin
         @(negedge clk) link_fail = 1'b1;
         @(negedge clk);
         check(crs == 1'b0 && rxdv == 1'b0, "R7 link fail blocks", int'({crs, rxdv}), 0);
         sop = 1'b1;
         @(negedge clk) sop = 1'b0;
         @(negedge clk);
         check(crs == 1'b0, "R7 sop ignored in link fail", int'(crs), 0);
         link_fail = 1'b0;
         @(negedge clk);
         check(crs == 1'b0, "R7 idle after release", int'(crs), 0);
      end else begin
         @(negedge clk) eop = 1'b1;
         @(negedge clk) eop = 1'b0;
         check(crs == 1'b0 && rxdv == 1'b0, "R6 end clears crs and rxdv",
               int'({crs, rxdv}), 0);
         check(rxd == 4'd0, "R6 rxd zero after end", int'(rxd), 0);
      end
      rec_lock = 1'b0;
      repeat (120) @(negedge clk);
      check(in_band(last_hi, TXH), "R6 rxclk back on tx_clk", last_hi, TXH);
   endtask

   // Watchdog.
   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog run incomplete actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (10) @(negedge clk);
      check(crs == 1'b0 && rxdv == 1'b0, "R2 reset crs rxdv", int'({crs, rxdv}), 0);
      check(rxd == 4'd0, "R2 reset rxd", int'(rxd), 0);
      check(rxer == 1'b0, "R1 reset rxer", int'(rxer), 0);
      rst_n = 1'b1;

      // R2: squelch invalid, sop has no effect, clock from tx_clk
      @(negedge clk) sop = 1'b1;
      @(negedge clk) sop = 1'b0;
      check(crs == 1'b0, "R2 sop ignored while squelched", int'(crs), 0);
      repeat (80) @(negedge clk);
      check(in_band(last_hi, TXH), "R2 idle rxclk from tx_clk", last_hi, TXH);
      squelch_ok = 1'b1;

      // R11: sop and eop together while idle
      @(negedge clk) begin sop = 1'b1; eop = 1'b1; end
      @(negedge clk) begin sop = 1'b0; eop = 1'b0; end
      check(crs == 1'b0, "R11 simultaneous sop eop", int'(crs), 0);
      @(negedge clk);
      check(crs == 1'b0, "R11 still idle", int'(crs), 0);

      // Directed packet
      run_packet(5, 6, 0);

      // R8: end before lock
      rxdv_ever = 1'b0;
      @(negedge clk) sop = 1'b1;
      @(negedge clk) sop = 1'b0;
      check(crs == 1'b1, "R8 carrier up", int'(crs), 1);
      repeat (60) @(negedge clk);
      @(negedge clk) eop = 1'b1;
      @(negedge clk) eop = 1'b0;
      check(crs == 1'b0, "R8 carrier down", int'(crs), 0);
      repeat (80) @(negedge clk);
      check(rxdv_ever == 1'b0, "R8 no valid without lock", int'(rxdv_ever), 0);

      // R10: squelch loss during carrier
      @(negedge clk) sop = 1'b1;
      @(negedge clk) sop = 1'b0;
      @(negedge clk) squelch_ok = 1'b0;
      @(negedge clk);
      check(crs == 1'b0, "R10 squelch loss in carrier", int'(crs), 0);
      squelch_ok = 1'b1;

      // Directed link fail and squelch endings
      run_packet(1, 3, 3);
      run_packet(12, 4, 2);

      // Random packets
      for (int p = 0; p < 12; p++) begin
         run_packet(1 + int'($urandom % 30), 2 + int'($urandom % 8), int'($urandom % 4));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule